// File: doc/BRIEF.md
# Conditional Data-Processing ALU

This block is the execute-stage arithmetic and logic unit of a 32-bit integer core. It receives a 4-bit operation code, a first operand, a second operand that an upstream shifter has already shifted, and the shifter's carry-out. It also receives a flag that says whether the shift amount was nonzero, the set-flags bit, a 4-bit condition field and the current N, Z, C and V flags. It returns the operation result, an execute-enable, a destination-write enable and the next value of the four flags.

The unit is purely combinational. First the condition field is tested against the incoming flags. When the test fails, the instruction has no effect: nothing is written and the flags pass through unchanged. When the test passes, the result is produced. The flags are updated according to the operation class and the set-flags bit. Subtraction runs through the same adder as addition, with the second input inverted, so the carry out of a subtract is the inverse of a borrow.

Top module: `cc_alu`

## Requirements
- R1: Opcode encoding: 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. ADD/ADC give A+B(+cin), and SUB/SBC give A+~B+cin.
- R2: The logical and move results are: AND is A&B, EOR is A^B, ORR is A|B, BIC is A&~B, MOV is B and MVN is ~B.
- R3: The carry-in is 0 for ADD and CMN, 1 for SUB, RSB and CMP, and the incoming C flag for ADC, SBC and RSC. For every arithmetic operation the new C is bit 32 of the adder, so after a subtract C=1 means that no borrow occurred.
- R4: For arithmetic operations the new V is set exactly when the adder's signed result overflows.
- R5: Whenever flags update, N equals result bit 31 and Z is set exactly when the result is zero.
- R6: For logical, move and test operations, V keeps its incoming value. C takes the shifter carry-out when the shift amount is nonzero and otherwise keeps its incoming value.
- R7: Flags change only when the set-flags bit is 1, except that TST, TEQ, CMP and CMN always update the flags. Those four operations never assert the destination-write enable.
- R8: The flag bus order is {N,Z,C,V} (bit 3 is N). Condition codes 0 to 14 are EQ Z, NE !Z, CS C, CC !C, MI N, PL !N, VS V, VC !V, HI C&!Z, LS !C|Z, GE N==V, LT N!=V, GT !Z&(N==V), LE Z|(N!=V), AL always. Execute-enable follows that test.
- R9: Condition code 15 never executes. When the condition fails, the write enable is 0 and the flags out equal the flags in.
- R10: RSB and RSC swap the operands, so they compute B+~A+cin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| opa | input | 32 | First operand |
| opb | input | 32 | Shifted second operand |
| sh_cout | input | 1 | Shifter carry-out |
| sh_nz | input | 1 | Shift amount was nonzero |
| set_flags | input | 1 | Set-flags bit |
| cond | input | 4 | Condition field |
| flags_in | input | 4 | Current {N,Z,C,V} |
| result | output | 32 | Operation result |
| exec_en | output | 1 | Condition passed |
| wr_en | output | 1 | Write destination register |
| flags_out | output | 4 | Next {N,Z,C,V} |

## Verification
The bench targets the carry of subtraction in several cases. It tests a subtract with and without a borrow, and a subtract with carry when C is clear. A design that treats carry as a plain borrow would return C inverted and results off by one. Reverse subtracts check the operand swap, which a wrong design would hide by returning negated values. Logical operations are run with a zero and a nonzero shift amount, to catch a design that takes C from the adder or disturbs V. Every condition code is swept against several flag patterns, including code 15. Failed conditions with the set-flags bit high check that neither the flags nor the write enable leak through.

// File: rtl/cc_alu.sv
module cc_alu #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sh_cout,
  input  logic         sh_nz,
  input  logic         set_flags,
  input  logic [3:0]   cond,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result,
  output logic         exec_en,
  output logic         wr_en,
  output logic [3:0]   flags_out
);
  localparam int MSB = W - 1;

  logic fn, fz, fc, fv;
  assign {fn, fz, fc, fv} = flags_in;

  logic arith, test_op, swap, inv, cin;
  always_comb begin
    arith = 1'b0; swap = 1'b0; inv = 1'b0; cin = 1'b0;
    test_op = (op[3:2] == 2'b10);
    case (op)
      4'd2, 4'd10: begin arith = 1'b1; inv = 1'b1; cin = 1'b1; end
      4'd3:        begin arith = 1'b1; inv = 1'b1; cin = 1'b1; swap = 1'b1; end
      4'd4, 4'd11: begin arith = 1'b1; end
      4'd5:        begin arith = 1'b1; cin = fc; end
      4'd6:        begin arith = 1'b1; inv = 1'b1; cin = fc; end
      4'd7:        begin arith = 1'b1; inv = 1'b1; cin = fc; swap = 1'b1; end
      default: ;
    endcase
  end

  logic [W-1:0] ax, by;
  logic [W:0]   sum;
  assign ax  = swap ? opb : opa;
  assign by  = inv ? ~(swap ? opa : opb) : (swap ? opa : opb);
  assign sum = {1'b0, ax} + {1'b0, by} + {{W{1'b0}}, cin};

  always_comb begin
    case (op)
      4'd0, 4'd8:  result = opa & opb;
      4'd1, 4'd9:  result = opa ^ opb;
      4'd12:       result = opa | opb;
      4'd13:       result = opb;
      4'd14:       result = opa & ~opb;
      4'd15:       result = ~opb;
      default:     result = sum[MSB:0];
    endcase
  end

  logic pass;
  always_comb begin
    case (cond)
      4'd0:    pass = fz;
      4'd1:    pass = !fz;
      4'd2:    pass = fc;
      4'd3:    pass = !fc;
      4'd4:    pass = fn;
      4'd5:    pass = !fn;
      4'd6:    pass = fv;
      4'd7:    pass = !fv;
      4'd8:    pass = fc && !fz;
      4'd9:    pass = !fc || fz;
      4'd10:   pass = (fn == fv);
      4'd11:   pass = (fn != fv);
      4'd12:   pass = !fz && (fn == fv);
      4'd13:   pass = fz || (fn != fv);
      4'd14:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

  logic nc, nv;
  assign nc = arith ? sum[W] : (sh_nz ? sh_cout : fc);
  assign nv = arith ? ((ax[MSB] == by[MSB]) && (sum[MSB] != ax[MSB])) : fv;

  assign exec_en   = pass;
  assign wr_en     = pass && !test_op;
  assign flags_out = (pass && (set_flags || test_op))
                     ? {result[MSB], (result == '0), nc, nv} : flags_in;
endmodule

// File: rtl/cc_alu_chk.sv
module cc_alu_chk #(
  parameter int W = 32
) (
  input logic [3:0]   op,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         sh_cout,
  input logic         sh_nz,
  input logic         set_flags,
  input logic [3:0]   cond,
  input logic [3:0]   flags_in,
  input logic [W-1:0] result,
  input logic         exec_en,
  input logic         wr_en,
  input logic [3:0]   flags_out
);
  logic is_test, is_logic, upd;
  assign is_test  = (op >= 4'd8) && (op <= 4'd11);
  assign is_logic = (op == 4'd0) || (op == 4'd1) || (op == 4'd8) || (op == 4'd9) || (op >= 4'd12);
  assign upd      = exec_en && (set_flags || is_test);

  always_comb begin
    AST_FAIL_HOLDS: assert (exec_en || (!wr_en && flags_out == flags_in)); // R9
    AST_NEVER_CODE: assert (cond != 4'd15 || !exec_en); // R9
    AST_TEST_NOWR: assert (!is_test || !wr_en); // R7
    AST_NO_S_KEEP: assert (!exec_en || set_flags || is_test || flags_out == flags_in); // R7
    AST_NZ_TRACK: assert (!upd || (flags_out[3] == result[W-1] && flags_out[2] == (result == '0))); // R5
    AST_LOGIC_V: assert (!is_logic || flags_out[0] == flags_in[0]); // R6
    AST_LOGIC_C: assert (!(upd && is_logic) || flags_out[1] == (sh_nz ? sh_cout : flags_in[1])); // R6
    AST_AL_RUNS: assert (cond != 4'd14 || exec_en); // R8
  end
endmodule

bind cc_alu cc_alu_chk #(.W(W)) u_chk (
  .op(op), .opa(opa), .opb(opb), .sh_cout(sh_cout), .sh_nz(sh_nz),
  .set_flags(set_flags), .cond(cond), .flags_in(flags_in), .result(result),
  .exec_en(exec_en), .wr_en(wr_en), .flags_out(flags_out)
);

// File: tb/test_cc_alu.sv
module test_cc_alu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  op;
  logic [31:0] opa, opb;
  logic        sh_cout, sh_nz, set_flags;
  logic [3:0]  cond, flags_in;
  logic [31:0] result;
  logic        exec_en, wr_en;
  logic [3:0]  flags_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  cc_alu i_cc_alu (
    .op(op), .opa(opa), .opb(opb), .sh_cout(sh_cout), .sh_nz(sh_nz),
    .set_flags(set_flags), .cond(cond), .flags_in(flags_in),
    .result(result), .exec_en(exec_en), .wr_en(wr_en), .flags_out(flags_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic s, input logic [3:0] c, input logic [3:0] f,
                       input logic nz, input logic sc);
    @(negedge clk);
    op = o; opa = a; opb = b; set_flags = s; cond = c; flags_in = f;
    sh_nz = nz; sh_cout = sc;
    #2;
  endtask

  task automatic t_reset;
    chk("R1 idle result", result, 32'h0);
    chk("R8 idle exec", {31'b0, exec_en}, 1);
    chk("R7 idle flags", {28'b0, flags_out}, 0);
  endtask

  task automatic t_add;
    drive(4'd4, 32'd5, 32'd7, 1, 4'd14, 4'b0000, 0, 0);
    chk("R1 add", result, 32'd12); chk("R5 add flags", {28'b0, flags_out}, 4'b0000);
    drive(4'd4, 32'hFFFFFFFF, 32'd1, 1, 4'd14, 4'b0000, 0, 0);
    chk("R3 add wrap", result, 0); chk("R3 add carry", {28'b0, flags_out}, 4'b0110);
    drive(4'd4, 32'h7FFFFFFF, 32'd1, 1, 4'd14, 4'b0000, 0, 0);
    chk("R4 add ovf", {28'b0, flags_out}, 4'b1001);
    drive(4'd5, 32'd1, 32'd2, 1, 4'd14, 4'b0010, 0, 0);
    chk("R3 adc", result, 32'd4); chk("R3 adc flags", {28'b0, flags_out}, 4'b0000);
  endtask

  task automatic t_sub;
    drive(4'd2, 32'd5, 32'd3, 1, 4'd14, 4'b0000, 0, 0);
    chk("R3 sub", result, 32'd2); chk("R3 sub noborrow", {28'b0, flags_out}, 4'b0010);
    drive(4'd2, 32'd3, 32'd5, 1, 4'd14, 4'b0010, 0, 0);
    chk("R3 sub neg", result, 32'hFFFFFFFE); chk("R3 sub borrow", {28'b0, flags_out}, 4'b1000);
    drive(4'd2, 32'h80000000, 32'd1, 1, 4'd14, 4'b0000, 0, 0);
    chk("R4 sub ovf", {28'b0, flags_out}, 4'b0011);
    drive(4'd6, 32'd5, 32'd3, 1, 4'd14, 4'b0000, 0, 0);
    chk("R3 sbc C0", result, 32'd1); chk("R3 sbc flags", {28'b0, flags_out}, 4'b0010);
    drive(4'd6, 32'd5, 32'd3, 0, 4'd14, 4'b0010, 0, 0);
    chk("R3 sbc C1", result, 32'd2);
  endtask

  task automatic t_reverse;
    drive(4'd3, 32'd3, 32'd10, 1, 4'd14, 4'b0000, 0, 0);
    chk("R10 rsb", result, 32'd7); chk("R10 rsb flags", {28'b0, flags_out}, 4'b0010);
    drive(4'd7, 32'd3, 32'd10, 0, 4'd14, 4'b0000, 0, 0);
    chk("R10 rsc", result, 32'd6);
  endtask

  task automatic t_logic;
    drive(4'd0, 32'h0000F0F0, 32'h0000FF00, 1, 4'd14, 4'b0011, 0, 0);
    chk("R2 and", result, 32'h0000F000); chk("R6 and keep CV", {28'b0, flags_out}, 4'b0011);
    drive(4'd12, 32'h1, 32'h80000000, 1, 4'd14, 4'b0010, 1, 0);
    chk("R2 orr", result, 32'h80000001); chk("R6 orr shc", {28'b0, flags_out}, 4'b1000);
    drive(4'd1, 32'h1234, 32'h1234, 1, 4'd14, 4'b0001, 1, 1);
    chk("R2 eor", result, 0); chk("R6 eor flags", {28'b0, flags_out}, 4'b0111);
    drive(4'd14, 32'hFF, 32'h0F, 0, 4'd14, 4'b0000, 0, 0);
    chk("R2 bic", result, 32'hF0);
    drive(4'd13, 32'h0, 32'h1234, 0, 4'd14, 4'b0000, 0, 0);
    chk("R2 mov", result, 32'h1234); chk("R7 mov wr", {31'b0, wr_en}, 1);
    drive(4'd15, 32'h0, 32'h0, 1, 4'd14, 4'b0000, 0, 0);
    chk("R2 mvn", result, 32'hFFFFFFFF); chk("R5 mvn N", {28'b0, flags_out}, 4'b1000);
  endtask

  task automatic t_sbit;
    drive(4'd4, 32'hFFFFFFFF, 32'd1, 0, 4'd14, 4'b1001, 0, 0);
    chk("R7 no S flags", {28'b0, flags_out}, 4'b1001); chk("R7 no S wr", {31'b0, wr_en}, 1);
  endtask

  task automatic t_compare;
    drive(4'd10, 32'd5, 32'd5, 0, 4'd14, 4'b0000, 0, 0);
    chk("R7 cmp flags", {28'b0, flags_out}, 4'b0110); chk("R7 cmp wr", {31'b0, wr_en}, 0);
    drive(4'd11, 32'd1, 32'hFFFFFFFF, 0, 4'd14, 4'b0000, 0, 0);
    chk("R7 cmn flags", {28'b0, flags_out}, 4'b0110);
    drive(4'd8, 32'hF0, 32'h0F, 0, 4'd14, 4'b0000, 0, 0);
    chk("R7 tst flags", {28'b0, flags_out}, 4'b0100); chk("R7 tst wr", {31'b0, wr_en}, 0);
    drive(4'd9, 32'h80000000, 32'h0, 0, 4'd14, 4'b0000, 0, 0);
    chk("R7 teq flags", {28'b0, flags_out}, 4'b1000);
  endtask

  function automatic bit exp_pass(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cc = f[1], v = f[0];
    case (c)
      0: return z;        1: return !z;
      2: return cc;       3: return !cc;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return cc && !z; 9: return !cc || z;
      10: return n == v;  11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_cond;
    logic [3:0] pats [6] = '{4'b0000, 4'b0100, 4'b0010, 4'b1000, 4'b1001, 4'b0110};
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < 16; c++) begin
        bit e;
        e = exp_pass(4'(c), pats[p]);
        drive(4'd13, 32'h0, 32'h0, 1, 4'(c), pats[p], 0, 0);
        chk($sformatf("R8 cond %0d flags %b exec", c, pats[p]), {31'b0, exec_en}, {31'b0, e});
        if (!e) begin
          chk("R9 fail flags", {28'b0, flags_out}, {28'b0, pats[p]});
          chk("R9 fail wr", {31'b0, wr_en}, 0);
        end
      end
    end
    drive(4'd4, 32'hFFFFFFFF, 32'd1, 1, 4'd0, 4'b1001, 0, 0);
    chk("R9 add EQ fail flags", {28'b0, flags_out}, 4'b1001);
    chk("R9 add EQ fail wr", {31'b0, wr_en}, 0);
  endtask

  initial begin
    op = 4'd13; opa = 0; opb = 0; set_flags = 0; cond = 4'd14; flags_in = 0;
    sh_nz = 0; sh_cout = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    t_reset;
    t_add;
    t_sub;
    t_reverse;
    t_logic;
    t_sbit;
    t_compare;
    t_cond;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule